// File: doc/BRIEF.md
# Console Bus Enable and Port Read Controller

This block sits on the bus of an 8-bit CPU in a home console. It keeps two write-only registers: a slot-enable register, whose upper six bits switch memory slots on and off, and an 8-bit port-control register whose value is brought straight out to pins. The CPU loads both through I/O write cycles. The block also forms six active-low slot enables and steers one of two controller input groups onto the CPU data bus during I/O reads.

The slot enables are not address decodes. Each one is the OR of an active-low bus strobe and one enable-register bit, so a bit value of 1 keeps that slot off. A kill input blocks every I/O cycle the block would otherwise see. While it is high, neither register can be written and the data bus is never driven. The bus signals are treated as synchronous to `clk`. A register write takes effect at the first clock edge that samples the write strobe high again after it was low.

There is no data stream in this block. Every pin is a plain level, and there is no valid/ready handshake and no back-pressure.

Top module: `bus_enable_ctl`

## Requirements
- R1: While reset is low, and once it is released, enable-register bits 7..5 read as 1 and bits 4..2 read as 0. Slot enables `ce_n[2:0]` are therefore allowed and `ce_n[5:3]` are blocked. The port-control register holds 0xFF.
- R2: An I/O write is a cycle with `iorq_n` low, `wr_n` low and `a_hi` equal to 2'b00. It loads `din` into the enable register when `a0`=0 and into the port-control register when `a0`=1. The load happens at the clock edge that first samples `wr_n` high again. Any other `a_hi` value, or `iorq_n` high, leaves both registers unchanged.
- R3: Bits 1 and 0 of a value written to the enable register are discarded, so no output depends on them.
- R4: When `kill` is high during the strobe of an I/O write, neither register changes.
- R5: `ce_n[0]` equals `mreq_n` OR enable bit 2.
- R6: `ce_n[1]` equals `ram_cs_n` OR enable bit 3. It does not depend on `mreq_n`.
- R7: For k from 2 to 5, `ce_n[k]` equals `mreq_n` OR enable bit k+2.
- R8: A port read is a cycle with `iorq_n` low, `rd_n` low, `kill` low and `a_hi` equal to 2'b11. During a port read `d_oe` is 1 and `d_out` carries `grp_a` when `a0`=0 and `grp_b` when `a0`=1.
- R9: Outside a port read `d_oe` is 0. In particular, `kill` high removes the drive even when every other condition for a read holds.
- R10: `pctl` always shows the current content of the port-control register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| iorq_n | input | 1 | I/O request strobe, active low |
| mreq_n | input | 1 | Memory request strobe, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| a_hi | input | 2 | CPU address bits 7 and 6 |
| a0 | input | 1 | CPU address bit 0 |
| din | input | 8 | CPU data bus, write direction |
| kill | input | 1 | High blocks all I/O cycles |
| ram_cs_n | input | 1 | External RAM select, active low |
| grp_a | input | 8 | Controller input group returned when a0=0 |
| grp_b | input | 8 | Controller input group returned when a0=1 |
| ce_n | output | 6 | Active-low slot enables |
| pctl | output | 8 | Port-control register content |
| d_out | output | 8 | Read data toward the CPU bus |
| d_oe | output | 1 | Drive enable for d_out; 0 means high-impedance |

## Verification
An enable-register write can complete while `mreq_n` is already held low. In that case the slot enables must switch in the cycle after the load edge, with no stale or intermediate pattern. The bench holds `mreq_n` and `ram_cs_n` low through every write, then samples `ce_n` just after the load edge. It compares the result against a model of the written bits 7..2. The second collision is `kill` rising during the write strobe, where the write and the kill arrive together. The bench judges it by confirming afterwards that both `ce_n` and `pctl` still hold their earlier values.

// File: rtl/bec_pkg.sv
package bec_pkg;
  localparam int EN_LSB   = 2;
  localparam int EN_W     = 6;
  localparam int NUM_CE   = 6;
  localparam logic [EN_W-1:0] EN_RST = 6'b111000;
  localparam logic [1:0] A_REGS = 2'b00;
  localparam logic [1:0] A_PORTS = 2'b11;
  typedef enum logic { SEL_ENABLE = 1'b0, SEL_PCTL = 1'b1 } reg_sel_e;
endpackage

// File: rtl/bec_regs.sv
module bec_regs
  import bec_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            iorq_n,
  input  logic            wr_n,
  input  logic            kill,
  input  logic [1:0]      a_hi,
  input  logic            a0,
  input  logic [DW-1:0]   din,
  output logic [EN_W-1:0] en_bits,
  output logic [DW-1:0]   pctl
);
  logic          wr_q;
  logic          hit_q;
  reg_sel_e      sel_q;
  logic [DW-1:0] data_q;
  logic          commit;
  logic [EN_W-1:0] en_q;
  logic [DW-1:0]   pctl_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_q   <= 1'b1;
      hit_q  <= 1'b0;
      sel_q  <= SEL_ENABLE;
      data_q <= '0;
    end else begin
      wr_q   <= wr_n;
      hit_q  <= !iorq_n && !kill && !wr_n && (a_hi == A_REGS);
      sel_q  <= reg_sel_e'(a0);
      data_q <= din;
    end
  end

  assign commit = hit_q && !wr_q && wr_n;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q   <= EN_RST;
      pctl_q <= '1;
    end else if (commit) begin
      if (sel_q == SEL_ENABLE) en_q <= data_q[EN_LSB+EN_W-1:EN_LSB];
      else                     pctl_q <= data_q;
    end
  end

  assign en_bits = en_q;
  assign pctl    = pctl_q;

  AST_KILL_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    kill |=> ($stable(en_q) && $stable(pctl_q))); // R4
  AST_UPDATE_ON_WR_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    !($stable(en_q) && $stable(pctl_q)) |-> ($past(wr_n) && !$past(wr_n, 2))); // R2
endmodule

// File: rtl/bec_ce.sv
module bec_ce
  import bec_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mreq_n,
  input  logic              ram_cs_n,
  input  logic [EN_W-1:0]   en_bits,
  output logic [NUM_CE-1:0] ce_n
);
  assign ce_n[0] = mreq_n | en_bits[0];
  assign ce_n[1] = ram_cs_n | en_bits[1];

  for (genvar k = 2; k < NUM_CE; k++) begin : g_slot
    assign ce_n[k] = mreq_n | en_bits[k];
  end

  AST_RAM_CE_IGNORES_MREQ: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_cs_n && $stable(ram_cs_n)) |-> ce_n[1]); // R6
  AST_IDLE_BUS_NO_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    mreq_n |-> (ce_n[0] && ce_n[NUM_CE-1])); // R5
endmodule

// File: rtl/bec_portmux.sv
module bec_portmux
  import bec_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          iorq_n,
  input  logic          rd_n,
  input  logic          kill,
  input  logic [1:0]    a_hi,
  input  logic          a0,
  input  logic [DW-1:0] grp_a,
  input  logic [DW-1:0] grp_b,
  output logic [DW-1:0] d_out,
  output logic          d_oe
);
  for (genvar i = 0; i < DW; i++) begin : g_bit
    assign d_out[i] = a0 ? grp_b[i] : grp_a[i];
  end

  assign d_oe = !iorq_n && !rd_n && !kill && (a_hi == A_PORTS);
endmodule

// File: rtl/bus_enable_ctl.sv
module bus_enable_ctl
  import bec_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              iorq_n,
  input  logic              mreq_n,
  input  logic              rd_n,
  input  logic              wr_n,
  input  logic [1:0]        a_hi,
  input  logic              a0,
  input  logic [DW-1:0]     din,
  input  logic              kill,
  input  logic              ram_cs_n,
  input  logic [DW-1:0]     grp_a,
  input  logic [DW-1:0]     grp_b,
  output logic [NUM_CE-1:0] ce_n,
  output logic [DW-1:0]     pctl,
  output logic [DW-1:0]     d_out,
  output logic              d_oe
);
  logic [EN_W-1:0] en_bits;

  bec_regs #(.DW(DW)) u_regs (
    .clk(clk), .rst_n(rst_n), .iorq_n(iorq_n), .wr_n(wr_n), .kill(kill),
    .a_hi(a_hi), .a0(a0), .din(din), .en_bits(en_bits), .pctl(pctl)
  );

  bec_ce u_ce (
    .clk(clk), .rst_n(rst_n), .mreq_n(mreq_n), .ram_cs_n(ram_cs_n),
    .en_bits(en_bits), .ce_n(ce_n)
  );

  bec_portmux #(.DW(DW)) u_mux (
    .iorq_n(iorq_n), .rd_n(rd_n), .kill(kill), .a_hi(a_hi), .a0(a0),
    .grp_a(grp_a), .grp_b(grp_b), .d_out(d_out), .d_oe(d_oe)
  );

  AST_KILL_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    kill |-> !d_oe); // R9
  AST_DRIVE_ONLY_PORTS: assert property (@(posedge clk) disable iff (!rst_n)
    d_oe |-> (a_hi == A_PORTS && !rd_n && !iorq_n)); // R8
endmodule

// File: tb/sim_bus_enable_ctl.sv
module sim_bus_enable_ctl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic iorq_n = 1'b1, mreq_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
  logic [1:0] a_hi = 2'b00;
  logic a0 = 1'b0;
  logic [7:0] din = 8'h00;
  logic kill = 1'b0, ram_cs_n = 1'b1;
  logic [7:0] grp_a = 8'h00, grp_b = 8'h00;
  logic [5:0] ce_n;
  logic [7:0] pctl, d_out;
  logic d_oe;

  int checks = 0;
  int errors = 0;
  logic [5:0] en_m;
  logic [7:0] pc_m;

  always #2 clk = ~clk;

  bus_enable_ctl u0 (
    .clk(clk), .rst_n(rst_n), .iorq_n(iorq_n), .mreq_n(mreq_n), .rd_n(rd_n),
    .wr_n(wr_n), .a_hi(a_hi), .a0(a0), .din(din), .kill(kill),
    .ram_cs_n(ram_cs_n), .grp_a(grp_a), .grp_b(grp_b), .ce_n(ce_n),
    .pctl(pctl), .d_out(d_out), .d_oe(d_oe)
  );

  task automatic chk(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [5:0] ce_exp(input logic [5:0] en, input logic mq, input logic rc);
    logic [5:0] r;
    r[0] = mq | en[0];
    r[1] = rc | en[1];
    for (int k = 2; k < 6; k++) r[k] = mq | en[k];
    return r;
  endfunction

  task automatic io_write(input logic [1:0] ah, input logic a, input logic [7:0] d, input logic kl, input logic iq);
    @(negedge clk);
    a_hi = ah; a0 = a; din = d; kill = kl; iorq_n = iq; wr_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    wr_n = 1'b1;
    @(negedge clk);
    iorq_n = 1'b1; kill = 1'b0;
    @(negedge clk);
  endtask

  task automatic check_state(input string req);
    for (int m = 0; m < 4; m++) begin
      mreq_n = m[0]; ram_cs_n = m[1];
      #0.5;
      chk(ce_n === ce_exp(en_m, m[0], m[1]), req, {10'd0, ce_n}, {10'd0, ce_exp(en_m, m[0], m[1])});
    end
    chk(pctl === pc_m, "R10", {8'd0, pctl}, {8'd0, pc_m});
    mreq_n = 1'b0; ram_cs_n = 1'b0;
  endtask

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    en_m = 6'b111000; pc_m = 8'hFF;
    mreq_n = 1'b0; ram_cs_n = 1'b0;
    repeat (3) @(negedge clk);
    #0.5;
    chk(ce_n === 6'b111000, "R1 in reset", {10'd0, ce_n}, 16'h0038);
    chk(pctl === 8'hFF, "R1 in reset", {8'd0, pctl}, 16'h00FF);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    check_state("R1");

    // R2 R3 R5 R6 R7: every enable value; mreq_n and ram_cs_n held low across the write
    for (int v = 0; v < 256; v++) begin
      io_write(2'b00, 1'b0, v[7:0], 1'b0, 1'b0);
      en_m = v[7:2];
      check_state("R2 R5 R6 R7 enable write");
      io_write(2'b00, 1'b0, v[7:0] ^ 8'h03, 1'b0, 1'b0);
      check_state("R3 low bits ignored");
    end

    // R2 R10: every port-control value
    for (int v = 0; v < 256; v++) begin
      io_write(2'b00, 1'b1, v[7:0], 1'b0, 1'b0);
      pc_m = v[7:0];
      chk(pctl === pc_m, "R10 pctl write", {8'd0, pctl}, {8'd0, pc_m});
    end
    check_state("R2 enable untouched by pctl writes");

    // R2: foreign addresses and missing iorq_n
    for (int ah = 1; ah < 4; ah++) begin
      io_write(ah[1:0], 1'b0, 8'h00, 1'b0, 1'b0);
      io_write(ah[1:0], 1'b1, 8'h5A, 1'b0, 1'b0);
      check_state("R2 foreign address");
    end
    io_write(2'b00, 1'b0, 8'h00, 1'b0, 1'b1);
    io_write(2'b00, 1'b1, 8'h00, 1'b0, 1'b1);
    check_state("R2 no iorq");

    // R4: kill during write
    io_write(2'b00, 1'b0, 8'h54, 1'b1, 1'b0);
    io_write(2'b00, 1'b1, 8'h33, 1'b1, 1'b0);
    check_state("R4 kill blocks write");
    io_write(2'b00, 1'b1, 8'h33, 1'b0, 1'b0);
    pc_m = 8'h33;
    check_state("R4 write after kill released");

    // R8 R9: read sweep
    for (int p = 0; p < 4; p++) begin
      grp_a = 8'h11 * p[7:0] ^ 8'hA5; grp_b = ~grp_a ^ 8'h0F;
      for (int c = 0; c < 64; c++) begin
        @(negedge clk);
        a_hi = c[1:0]; a0 = c[2]; iorq_n = c[3]; rd_n = c[4]; kill = c[5];
        #0.5;
        if (c[1:0] == 2'b11 && !c[3] && !c[4] && !c[5]) begin
          chk(d_oe === 1'b1, "R8 drive", {15'd0, d_oe}, 16'd1);
          chk(d_out === (c[2] ? grp_b : grp_a), "R8 select", {8'd0, d_out},
              {8'd0, (c[2] ? grp_b : grp_a)});
        end else begin
          chk(d_oe === 1'b0, c[5] ? "R9 kill" : "R9 idle", {15'd0, d_oe}, 16'd0);
        end
      end
    end
    @(negedge clk);
    iorq_n = 1'b1; rd_n = 1'b1; kill = 1'b0;
    @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule